// File: doc/BRIEF.md
# Scan Instruction Register with Live Status Capture

This block is the instruction register of a boundary-scan test port. During an instruction scan it sits between the serial data input and the serial data output. When the TAP controller signals the capture state, the register loads a status word assembled from live device signals. While the shift strobe is high, that word leaves on the serial output, least significant bit first, and the new opcode enters at the most significant end. On the update strobe, the shifted contents are copied to a parallel opcode output. The test-logic-reset strobe returns that output to the all-ones bypass opcode.

A layout parameter selects one of two widths. The 16-bit wide layout reports the configuration result, the erase/program result, busy, configuration-mode and revision-done flags. The 8-bit narrow layout reports only the configuration-mode and security flags. Status is sampled only on the capture cycle, so a status change during the scan does not disturb the word that is shifting out. The TAP controller, the boundary cells and the programming engine are outside this block.

Top module: `tap_instr_reg`

## Requirements
- R1: In the wide layout, captured bits [15:9] are 0.
- R2: In the wide layout, captured bits [8:7] are "10" (bit 8 = 1, bit 7 = 0) when `cfg_ok_i` is 1, and "01" when it is 0.
- R3: In the wide layout, captured bits [6:5] use the same encoding driven by `prog_ok_i`: "10" for success, "01" for failure.
- R4: In the wide layout, captured bit 4 is `prog_busy_i`, bit 3 is `cfg_mode_i` and bit 2 is `rev_done_i`.
- R5: In both layouts, captured bits [1:0] are "01" (bit 0 = 1, bit 1 = 0).
- R6: In the narrow layout, captured bits [7:5] are 0, bit 4 is `cfg_mode_i`, bit 3 is `secure_i` and bit 2 is 0.
- R7: Each rising TCK edge with `shift_ir_i` high moves the chain one place toward bit 0 and loads `tdi_i` into the top bit. `tdo_o` shows chain bit 0 and changes on the falling TCK edge.
- R8: Status inputs are sampled only on a rising edge with `capture_ir_i` high. Changes at any other time do not alter the shifted-out word.
- R9: A rising edge with `update_ir_i` high copies the chain contents, as they stood before that edge, to `instr_o`. `instr_o` changes at no other time, except on reset.
- R10: When `tlr_i` is high at a rising edge, `instr_o` becomes all ones (bypass) and the chain is cleared, so `tdo_o` reads 0 after the next falling edge. Reset overrides every other strobe.
- R11: With no strobe high, the chain holds its value. When capture and shift are high together, capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tlr_i | input | 1 | Test-logic-reset state strobe, synchronous |
| capture_ir_i | input | 1 | Capture-IR state strobe |
| shift_ir_i | input | 1 | Shift-IR state strobe |
| update_ir_i | input | 1 | Update-IR state strobe |
| tdi_i | input | 1 | Serial data in |
| cfg_ok_i | input | 1 | Last configuration operation succeeded |
| prog_ok_i | input | 1 | Last erase/program operation succeeded |
| prog_busy_i | input | 1 | Erase/program in progress |
| cfg_mode_i | input | 1 | Device is in configuration mode |
| rev_done_i | input | 1 | Selected revision fully programmed |
| secure_i | input | 1 | Security option enabled |
| tdo_o | output | 1 | Serial data out, falling-edge timed |
| instr_o | output | IR_LEN | Updated instruction |

## Verification
The bench runs one wide instance and one narrow instance side by side, with the same stimulus, against a queue-based model. Its main targets are these:
- Swapped result-code polarity, which would show the success and failure patterns exchanged on the serial output.
- Status toggled during the shift, which would leak into the outgoing word if the design sampled live status rather than holding the captured value.
- Capture and shift asserted in the same cycle, where the wrong priority would drop the captured word.
- Update after a partial shift and reset in the middle of a scan, which catch an opcode output that moves at the wrong time or resets to the wrong value.

// File: rtl/tap_ir_pkg.sv
package tap_ir_pkg;

   typedef enum int {
      IR_NARROW = 0,
      IR_WIDE   = 1
   } ir_layout_e;

   typedef struct packed {
      logic cfg_ok;
      logic prog_ok;
      logic prog_busy;
      logic cfg_mode;
      logic rev_done;
      logic secure;
   } ir_status_t;

   localparam logic [1:0] IR_FIXED_LSBS = 2'b01;
   localparam int         IR_WIDE_LEN   = 16;
   localparam int         IR_NARROW_LEN = 8;

   function automatic int ir_len_of(ir_layout_e l);
      return (l == IR_WIDE) ? IR_WIDE_LEN : IR_NARROW_LEN;
   endfunction

   function automatic logic [1:0] result_code(logic ok);
      return ok ? 2'b10 : 2'b01;
   endfunction

endpackage

// File: rtl/tap_ir_capture_map.sv
module tap_ir_capture_map
   import tap_ir_pkg::*;
#(
   parameter ir_layout_e LAYOUT = IR_WIDE,
   parameter int         N      = ir_len_of(LAYOUT)
) (
   input  ir_status_t     st_i,
   output logic [N-1:0]   pattern_o
);

   localparam int RSVD_LO_WIDE   = 9;
   localparam int RSVD_LO_NARROW = 5;

   if (N != ir_len_of(LAYOUT)) begin : g_len_chk
      $error("tap_ir_capture_map: N does not match layout");
   end

   if (LAYOUT == IR_WIDE) begin : g_wide
      logic unused_wide;
      assign unused_wide = st_i.secure;
      always_comb begin
         pattern_o                     = '0;
         pattern_o[N-1:RSVD_LO_WIDE]   = '0;
         pattern_o[8:7]                = result_code(st_i.cfg_ok);
         pattern_o[6:5]                = result_code(st_i.prog_ok);
         pattern_o[4]                  = st_i.prog_busy;
         pattern_o[3]                  = st_i.cfg_mode;
         pattern_o[2]                  = st_i.rev_done;
         pattern_o[1:0]                = IR_FIXED_LSBS;
      end
   end else begin : g_narrow
      logic unused_narrow;
      assign unused_narrow = ^{st_i.cfg_ok, st_i.prog_ok, st_i.prog_busy, st_i.rev_done};
      always_comb begin
         pattern_o                     = '0;
         pattern_o[N-1:RSVD_LO_NARROW] = '0;
         pattern_o[4]                  = st_i.cfg_mode;
         pattern_o[3]                  = st_i.secure;
         pattern_o[2]                  = 1'b0;
         pattern_o[1:0]                = IR_FIXED_LSBS;
      end
   end

endmodule

// File: rtl/tap_ir_shift_chain.sv
module tap_ir_shift_chain #(
   parameter int N = 16
) (
   input  logic         tck,
   input  logic         tlr_i,
   input  logic         capture_i,
   input  logic         shift_i,
   input  logic         tdi_i,
   input  logic [N-1:0] load_val_i,
   output logic [N-1:0] chain_o,
   output logic         tdo_o
);

   if (N < 2) begin : g_n_chk
      $error("tap_ir_shift_chain: N must be at least 2");
   end

   logic [N-1:0] chain_q;
   logic         tdo_q;

   always_ff @(posedge tck) begin
      if (tlr_i)          chain_q <= '0;
      else if (capture_i) chain_q <= load_val_i;
      else if (shift_i)   chain_q <= {tdi_i, chain_q[N-1:1]};
   end

   always_ff @(negedge tck) begin
      tdo_q <= chain_q[0];
   end

   assign chain_o = chain_q;
   assign tdo_o   = tdo_q;

   AST_SHIFT_MSB: assert property (@(posedge tck) disable iff (tlr_i)
      (shift_i && !capture_i) |=> chain_q[N-1] == $past(tdi_i)); // R7
   AST_SHIFT_MOVE: assert property (@(posedge tck) disable iff (tlr_i)
      (shift_i && !capture_i) |=> chain_q[N-2:0] == $past(chain_q[N-1:1])); // R7
   AST_TDO_LSB: assert property (@(posedge tck) disable iff (tlr_i)
      tdo_o == chain_q[0]); // R7
   AST_CHAIN_HOLD: assert property (@(posedge tck) disable iff (tlr_i)
      (!capture_i && !shift_i) |=> $stable(chain_q)); // R11
   AST_CHAIN_CLEAR: assert property (@(posedge tck)
      tlr_i |=> chain_q == '0); // R10

endmodule

// File: rtl/tap_ir_hold.sv
module tap_ir_hold #(
   parameter int           N       = 16,
   parameter logic [N-1:0] RST_VAL = '1
) (
   input  logic         tck,
   input  logic         tlr_i,
   input  logic         update_i,
   input  logic [N-1:0] chain_i,
   output logic [N-1:0] instr_o
);

   logic [N-1:0] instr_q;

   always_ff @(posedge tck) begin
      if (tlr_i)         instr_q <= RST_VAL;
      else if (update_i) instr_q <= chain_i;
   end

   assign instr_o = instr_q;

   AST_INSTR_HOLD: assert property (@(posedge tck) disable iff (tlr_i)
      !update_i |=> $stable(instr_q)); // R9
   AST_INSTR_LOAD: assert property (@(posedge tck) disable iff (tlr_i)
      update_i |=> instr_q == $past(chain_i)); // R9
   AST_TLR_BYPASS: assert property (@(posedge tck)
      tlr_i |=> instr_q == RST_VAL); // R10

endmodule

// File: rtl/tap_instr_reg.sv
module tap_instr_reg
   import tap_ir_pkg::*;
#(
   parameter ir_layout_e  LAYOUT       = IR_WIDE,
   parameter logic [15:0] RESET_OPCODE = 16'hFFFF,
   localparam int         IR_LEN       = ir_len_of(LAYOUT)
) (
   input  logic              tck,
   input  logic              tlr_i,
   input  logic              capture_ir_i,
   input  logic              shift_ir_i,
   input  logic              update_ir_i,
   input  logic              tdi_i,
   input  logic              cfg_ok_i,
   input  logic              prog_ok_i,
   input  logic              prog_busy_i,
   input  logic              cfg_mode_i,
   input  logic              rev_done_i,
   input  logic              secure_i,
   output logic              tdo_o,
   output logic [IR_LEN-1:0] instr_o
);

   localparam logic [IR_LEN-1:0] RST_OP = RESET_OPCODE[IR_LEN-1:0];

   if (RESET_OPCODE[1:0] != 2'b11) begin : g_op_chk
      $error("tap_instr_reg: reset opcode must be a bypass-style code");
   end

   ir_status_t        st;
   logic [IR_LEN-1:0] cap_pattern;
   logic [IR_LEN-1:0] chain;

   assign st = '{cfg_ok:    cfg_ok_i,
                 prog_ok:   prog_ok_i,
                 prog_busy: prog_busy_i,
                 cfg_mode:  cfg_mode_i,
                 rev_done:  rev_done_i,
                 secure:    secure_i};

   tap_ir_capture_map #(.LAYOUT(LAYOUT), .N(IR_LEN)) u_map (
      .st_i      (st),
      .pattern_o (cap_pattern)
   );

   tap_ir_shift_chain #(.N(IR_LEN)) u_chain (
      .tck        (tck),
      .tlr_i      (tlr_i),
      .capture_i  (capture_ir_i),
      .shift_i    (shift_ir_i),
      .tdi_i      (tdi_i),
      .load_val_i (cap_pattern),
      .chain_o    (chain),
      .tdo_o      (tdo_o)
   );

   tap_ir_hold #(.N(IR_LEN), .RST_VAL(RST_OP)) u_hold (
      .tck      (tck),
      .tlr_i    (tlr_i),
      .update_i (update_ir_i),
      .chain_i  (chain),
      .instr_o  (instr_o)
   );

   AST_FIXED_LSBS: assert property (@(posedge tck) disable iff (tlr_i)
      capture_ir_i |=> chain[1:0] == 2'b01); // R5

   if (LAYOUT == IR_WIDE) begin : g_wide_chk
      AST_RSVD_ZERO: assert property (@(posedge tck) disable iff (tlr_i)
         capture_ir_i |=> chain[15:9] == 7'd0); // R1
      AST_CFG_CODE: assert property (@(posedge tck) disable iff (tlr_i)
         capture_ir_i |=> chain[8:7] == ($past(cfg_ok_i) ? 2'b10 : 2'b01)); // R2
      AST_PROG_CODE: assert property (@(posedge tck) disable iff (tlr_i)
         capture_ir_i |=> chain[6:5] == ($past(prog_ok_i) ? 2'b10 : 2'b01)); // R3
      AST_WIDE_FLAGS: assert property (@(posedge tck) disable iff (tlr_i)
         capture_ir_i |=> chain[4:2] == $past({prog_busy_i, cfg_mode_i, rev_done_i})); // R4
   end else begin : g_narrow_chk
      AST_NARROW_FIELDS: assert property (@(posedge tck) disable iff (tlr_i)
         capture_ir_i |=> chain[7:2] == {3'b000, $past(cfg_mode_i), $past(secure_i), 1'b0}); // R6
   end

endmodule

// File: tb/tap_instr_reg_tb_top.sv
`timescale 1ns/100ps
module tap_instr_reg_tb_top;
   import tap_ir_pkg::*;

   logic tck = 1'b0;
   always #2.5 tck = ~tck;

   logic tlr = 1'b1, cap = 1'b0, sh = 1'b0, upd = 1'b0, tdi = 1'b0;
   logic s_cfg_ok = 1'b1, s_prog_ok = 1'b1, s_busy = 1'b0;
   logic s_mode = 1'b0, s_done = 1'b0, s_sec = 1'b0;

   logic        tdo_w, tdo_n;
   logic [15:0] instr_w;
   logic [7:0]  instr_n;

   tap_instr_reg #(.LAYOUT(IR_WIDE)) dut_i (
      .tck(tck), .tlr_i(tlr), .capture_ir_i(cap), .shift_ir_i(sh),
      .update_ir_i(upd), .tdi_i(tdi), .cfg_ok_i(s_cfg_ok), .prog_ok_i(s_prog_ok),
      .prog_busy_i(s_busy), .cfg_mode_i(s_mode), .rev_done_i(s_done),
      .secure_i(s_sec), .tdo_o(tdo_w), .instr_o(instr_w));

   tap_instr_reg #(.LAYOUT(IR_NARROW)) dut_narrow_i (
      .tck(tck), .tlr_i(tlr), .capture_ir_i(cap), .shift_ir_i(sh),
      .update_ir_i(upd), .tdi_i(tdi), .cfg_ok_i(s_cfg_ok), .prog_ok_i(s_prog_ok),
      .prog_busy_i(s_busy), .cfg_mode_i(s_mode), .rev_done_i(s_done),
      .secure_i(s_sec), .tdo_o(tdo_n), .instr_o(instr_n));

   int    n_vec  = 0;
   int    n_fail = 0;
   string cur_req = "R10";

   bit wq[$];
   bit nq[$];
   int m_instr_w = 0;
   int m_instr_n = 0;

   function automatic int wide_word();
      int w = 0;
      w += 1;                                     // R5: bit0 = 1, bit1 = 0
      w += (s_done ? 1 : 0) << 2;                 // R4
      w += (s_mode ? 1 : 0) << 3;
      w += (s_busy ? 1 : 0) << 4;
      w += (s_prog_ok ? 2 : 1) << 5;              // R3: "10" ok, "01" fail
      w += (s_cfg_ok ? 2 : 1) << 7;               // R2
      return w;                                   // R1: upper bits left 0
   endfunction

   function automatic int narrow_word();
      return 1 + ((s_sec ? 1 : 0) << 3) + ((s_mode ? 1 : 0) << 4); // R6
   endfunction

   task automatic model_edge();
      int ow = 0;
      int on = 0;
      for (int i = 0; i < 16; i++) ow += (wq[i] ? 1 : 0) << i;
      for (int i = 0; i < 8; i++)  on += (nq[i] ? 1 : 0) << i;
      if (tlr) begin
         wq.delete(); nq.delete();
         for (int i = 0; i < 16; i++) wq.push_back(1'b0);
         for (int i = 0; i < 8; i++)  nq.push_back(1'b0);
         m_instr_w = 16'hFFFF; m_instr_n = 8'hFF;
      end else begin
         if (cap) begin
            int pw = wide_word();
            int pn = narrow_word();
            for (int i = 0; i < 16; i++) wq[i] = pw[i];
            for (int i = 0; i < 8; i++)  nq[i] = pn[i];
         end else if (sh) begin
            void'(wq.pop_front()); wq.push_back(tdi);
            void'(nq.pop_front()); nq.push_back(tdi);
         end
         if (upd) begin m_instr_w = ow; m_instr_n = on; end
      end
   endtask

   task automatic chk(string what, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
      end
   endtask

   task automatic step(bit c, bit s, bit u, bit r, bit d);
      cap = c; sh = s; upd = u; tlr = r; tdi = d;
      @(posedge tck);
      model_edge();
      @(negedge tck);
      #1;
      chk("wide tdo",     int'(tdo_w),   int'(wq[0]));
      chk("narrow tdo",   int'(tdo_n),   int'(nq[0]));
      chk("wide instr",   int'(instr_w), m_instr_w);
      chk("narrow instr", int'(instr_n), m_instr_n);
   endtask

   task automatic shift_bits(int word, int n);
      for (int i = 0; i < n; i++) step(0, 1, 0, 0, word[i]);
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      cur_req = "R10";
      repeat (3) step(0, 0, 0, 1, 0);
      chk("reset instr bypass", int'(instr_w), 16'hFFFF);

      cur_req = "R1/R2/R3/R4/R5/R6";
      s_cfg_ok = 1; s_prog_ok = 1; s_busy = 1; s_mode = 0; s_done = 1; s_sec = 1;
      step(1, 0, 0, 0, 0);
      cur_req = "R7";
      shift_bits(16'hA5C3, 16);
      cur_req = "R9";
      step(0, 0, 1, 0, 0);
      chk("wide opcode after update", int'(instr_w), 16'hA5C3);
      chk("narrow opcode after update", int'(instr_n), 8'hA5);

      cur_req = "R2/R3/R6";
      s_cfg_ok = 0; s_prog_ok = 0; s_busy = 0; s_mode = 1; s_done = 0; s_sec = 0;
      step(1, 0, 0, 0, 0);
      cur_req = "R8";
      for (int i = 0; i < 16; i++) begin
         s_cfg_ok = i[0]; s_prog_ok = ~i[1]; s_busy = i[0];
         s_mode = ~i[0]; s_done = i[1]; s_sec = i[2];
         step(0, 1, 0, 0, i[2]);
      end

      cur_req = "R11";
      s_cfg_ok = 1; s_prog_ok = 0; s_busy = 1; s_mode = 1; s_done = 1; s_sec = 1;
      step(1, 0, 0, 0, 0);
      shift_bits(16'h0015, 5);
      repeat (4) step(0, 0, 0, 0, 1);
      cur_req = "R9";
      step(0, 0, 1, 0, 0);
      repeat (3) step(0, 0, 0, 0, 0);

      cur_req = "R11";
      s_cfg_ok = 0; s_prog_ok = 1; s_busy = 0; s_mode = 0; s_done = 1; s_sec = 1;
      step(1, 1, 0, 0, 1);
      shift_bits(16'h3C0F, 16);
      step(0, 0, 1, 0, 0);

      cur_req = "R10";
      step(1, 0, 0, 0, 0);
      shift_bits(16'h00FF, 6);
      step(0, 1, 1, 1, 1);
      step(0, 0, 0, 0, 0);
      chk("tdo cleared after reset", int'(tdo_w), 0);
      chk("instr bypass after reset", int'(instr_n), 8'hFF);

      cur_req = "R5/R7";
      s_cfg_ok = 1; s_prog_ok = 1; s_busy = 0; s_mode = 1; s_done = 0; s_sec = 0;
      step(1, 0, 0, 0, 0);
      shift_bits(16'hFFFF, 16);
      step(0, 0, 1, 0, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule